// File: doc/BRIEF.md
# SDRAM Command Decoder with Two-Bank Tracking

This block sits on the device side of a two-bank synchronous DRAM interface. On every rising clock edge it samples clock enable, chip select, the three command strobes and a 12-bit address. From these it decodes one of seven commands and keeps an open or closed flag and the open row for each bank. It reports the decoded command, the address fields and an error pulse for any illegal sequence.

Bit 10 of the address has two meanings. On a read or write it asks for the addressed bank to close once the burst is over. On a precharge it selects both banks. The column width follows the configured data width. The burst length, which sets when an automatic close takes effect, is loaded by the mode register set command.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: After reset both banks are closed, `cmd_o` is NOP (0), `err_o` is low, both open rows and all address fields are zero, and the burst length is 1.
- R2: With `cke` high and `cs_n` low, the strobes {ras_n,cas_n,we_n} decode as follows: 011 activate (code 1), 101 read (2), 100 write (3), 010 precharge (4), 001 auto refresh (5), 000 mode register set (6). 111 and 110 decode as NOP (0).
- R3: With `cs_n` high the block reports NOP, raises no error and accepts no new command. A burst already running keeps counting, and its automatic close still happens.
- R4: When `cke` is sampled low the block reports NOP with `err_o` low. Bank state, open rows, address fields, burst length and the burst counter all hold.
- R5: An accepted activate opens bank `addr[11]` (0 = bank A, 1 = bank B) and records `addr[10:0]` as that bank's open row.
- R6: On any decoded command, `col_o` takes `addr[COL_W-1:0]`, `row_o` takes `addr[10:0]`, `bank_o` takes `addr[11]` and `ap_all_o` takes `addr[10]`. COL_W is 10, 9 or 8 for a data width of 4, 8 or 16.
- R7: A precharge with `addr[10]` high closes both banks whatever `addr[11]` is. With `addr[10]` low it closes only bank `addr[11]`.
- R8: An accepted read or write with `addr[10]` high closes bank `addr[11]` on the burst-length-th clock-enabled edge after the command edge. With `addr[10]` low the bank stays open. A later accepted read or write replaces the pending burst.
- R9: Mode register set loads a burst length of 2 to the power `addr[1:0]` (1, 2, 4 or 8).
- R10: A read or write to a closed bank, or an activate to an open bank, raises `err_o` and changes neither the bank state nor the burst.
- R11: Auto refresh with any bank open raises `err_o`. With both banks closed it is accepted and changes no state.
- R12: All outputs are registered. The result of a command sampled at one edge appears right after that edge, and `err_o` is high only for the cycle that follows the offending edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the block |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Address: bits 10:0 row/column, bit 10 flag, bit 11 bank |
| cmd_o | output | 3 | Decoded command code |
| err_o | output | 1 | Illegal-sequence pulse |
| row_o | output | 11 | Row field of the last decoded command |
| col_o | output | COL_W | Column field of the last decoded command |
| bank_o | output | 1 | Bank field of the last decoded command |
| ap_all_o | output | 1 | Bit 10 of the last decoded command |
| bank_open_o | output | 2 | Open flags, bit 0 bank A, bit 1 bank B |
| open_row_a_o | output | 11 | Open row of bank A |
| open_row_b_o | output | 11 | Open row of bank B |

## Verification
Each command result is registered once. A command driven before edge k therefore shows its decode, its error pulse and its bank-state change between edge k and edge k+1. The bench drives at the falling edge and compares at the next falling edge, which is half a cycle after the sampling edge.

An automatic close happens burst-length enabled edges after the command, so directed checks count only edges with `cke` high. They sample the bank flag one cycle before the close and again at the close. A bench-side model replays every edge of a long pseudo-random sweep and is compared with every output in that same half-cycle window.

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder #(
  parameter int DQ_WIDTH = 16,
  parameter int ROW_W    = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [ROW_W:0]       addr,
  output logic [2:0]           cmd_o,
  output logic                 err_o,
  output logic [ROW_W-1:0]     row_o,
  output logic [((DQ_WIDTH==4)?10:(DQ_WIDTH==8)?9:8)-1:0] col_o,
  output logic                 bank_o,
  output logic                 ap_all_o,
  output logic [1:0]           bank_open_o,
  output logic [ROW_W-1:0]     open_row_a_o,
  output logic [ROW_W-1:0]     open_row_b_o
);
  localparam int COL_W  = (DQ_WIDTH == 4) ? 10 : (DQ_WIDTH == 8) ? 9 : 8;
  localparam int FLAG_B = ROW_W - 1;
  localparam int CNT_W  = 4;

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD  = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_MRS = 3'd6;

  logic [2:0]       dec;
  logic [2:0]       cmd;
  logic             bsel, flag, err_d;
  logic [CNT_W-1:0] blen, cnt;
  logic             ap_pend, ap_bank;

  always_comb begin
    case ({ras_n, cas_n, we_n})
      3'b011:  dec = C_ACT;
      3'b101:  dec = C_RD;
      3'b100:  dec = C_WR;
      3'b010:  dec = C_PRE;
      3'b001:  dec = C_REF;
      3'b000:  dec = C_MRS;
      default: dec = C_NOP;
    endcase
  end

  assign cmd   = (cke && !cs_n) ? dec : C_NOP;
  assign bsel  = addr[ROW_W];
  assign flag  = addr[FLAG_B];
  assign err_d = ((cmd == C_ACT) && bank_open_o[bsel])
              || (((cmd == C_RD) || (cmd == C_WR)) && !bank_open_o[bsel])
              || ((cmd == C_REF) && (bank_open_o != 2'b00));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_o        <= C_NOP;
      err_o        <= 1'b0;
      row_o        <= '0;
      col_o        <= '0;
      bank_o       <= 1'b0;
      ap_all_o     <= 1'b0;
      bank_open_o  <= 2'b00;
      open_row_a_o <= '0;
      open_row_b_o <= '0;
      blen         <= CNT_W'(1);
      cnt          <= '0;
      ap_pend      <= 1'b0;
      ap_bank      <= 1'b0;
    end else if (cke) begin
      cmd_o <= cmd;
      err_o <= err_d;
      if (cmd != C_NOP) begin
        row_o    <= addr[ROW_W-1:0];
        col_o    <= addr[COL_W-1:0];
        bank_o   <= bsel;
        ap_all_o <= flag;
      end
      if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1) && ap_pend) begin
          bank_open_o[ap_bank] <= 1'b0;
          ap_pend              <= 1'b0;
        end
      end
      if (!err_d) begin
        case (cmd)
          C_ACT: begin
            bank_open_o[bsel] <= 1'b1;
            if (bsel) open_row_b_o <= addr[ROW_W-1:0];
            else      open_row_a_o <= addr[ROW_W-1:0];
          end
          C_RD, C_WR: begin
            cnt     <= blen;
            ap_pend <= flag;
            ap_bank <= bsel;
          end
          C_PRE: begin
            if (flag) bank_open_o       <= 2'b00;
            else      bank_open_o[bsel] <= 1'b0;
          end
          C_MRS: blen <= CNT_W'(1) << addr[1:0];
          default: ;
        endcase
      end
    end else begin
      cmd_o <= C_NOP;
      err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_cmd_decoder_chk.sv
module sdram_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       cs_n,
  input logic [2:0] cmd_o,
  input logic       err_o,
  input logic       bank_o,
  input logic       ap_all_o,
  input logic [1:0] bank_open_o
);
  logic [1:0] up;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up <= 2'd0;
    else if (up != 2'd2) up <= up + 2'd1;
  end

  assert_cke_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up == 2'd2) && !$past(cke) |-> (cmd_o == 3'd0) && !err_o && (bank_open_o == $past(bank_open_o)));

  assert_deselect_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up == 2'd2) && $past(cke) && $past(cs_n) |-> (cmd_o == 3'd0) && !err_o);

  assert_err_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (cmd_o == 3'd1) || (cmd_o == 3'd2) || (cmd_o == 3'd3) || (cmd_o == 3'd5));

  assert_pre_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd4) && ap_all_o |-> (bank_open_o == 2'b00));

  assert_ref_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd5) && !err_o |-> (bank_open_o == 2'b00));

  assert_act_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'd1) && !err_o |-> bank_open_o[bank_o]);
endmodule

bind sdram_cmd_decoder sdram_cmd_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .cmd_o(cmd_o), .err_o(err_o),
  .bank_o(bank_o), .ap_all_o(ap_all_o), .bank_open_o(bank_open_o)
);

// File: tb/sdram_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [2:0]  cmd_o;
  logic        err_o, bank_o, ap_all_o;
  logic [10:0] row_o, open_row_a_o, open_row_b_o;
  logic [7:0]  col_o;
  logic [1:0]  bank_open_o;

  always #2.5 clk = ~clk;

  sdram_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .cmd_o(cmd_o), .err_o(err_o), .row_o(row_o), .col_o(col_o),
    .bank_o(bank_o), .ap_all_o(ap_all_o), .bank_open_o(bank_open_o),
    .open_row_a_o(open_row_a_o), .open_row_b_o(open_row_b_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic [1:0]  m_open = 2'b00;
  logic [10:0] m_row [2] = '{default: '0};
  int          m_bl = 1, m_cnt = 0;
  bit          m_ap = 0, m_apb = 0;
  logic [2:0]  m_cmd = 0;
  bit          m_err = 0, m_bank = 0, m_flag = 0;
  logic [10:0] m_rowo = '0;
  logic [7:0]  m_col = '0;

  function automatic logic [2:0] spec_dec(input logic r, c, w);
    case ({r, c, w})
      3'b011: return 3'd1;
      3'b101: return 3'd2;
      3'b100: return 3'd3;
      3'b010: return 3'd4;
      3'b001: return 3'd5;
      3'b000: return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 cmd", 32'(cmd_o), 32'(m_cmd));
    chk("R10 err", 32'(err_o), 32'(m_err));
    chk("R7 bank_open", 32'(bank_open_o), 32'(m_open));
    chk("R5 row_a", 32'(open_row_a_o), 32'(m_row[0]));
    chk("R5 row_b", 32'(open_row_b_o), 32'(m_row[1]));
    chk("R6 col", 32'(col_o), 32'(m_col));
    chk("R6 row", 32'(row_o), 32'(m_rowo));
    chk("R12 bank", 32'(bank_o), 32'(m_bank));
    chk("R8 flag", 32'(ap_all_o), 32'(m_flag));
  endtask

  task automatic step(input logic k, input logic cs, input logic [2:0] rcw, input logic [11:0] a);
    logic [2:0] d;
    bit b, f, e;
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = rcw; addr = a;
    @(posedge clk);
    if (k) begin
      d = cs ? 3'd0 : spec_dec(rcw[2], rcw[1], rcw[0]);
      b = a[11]; f = a[10];
      e = (d == 3'd1 && m_open[b]) || ((d == 3'd2 || d == 3'd3) && !m_open[b])
          || (d == 3'd5 && m_open != 2'b00);
      if (m_cnt != 0) begin
        if (m_cnt == 1 && m_ap) begin m_open[m_apb] = 1'b0; m_ap = 0; end
        m_cnt--;
      end
      if (!e) begin
        case (d)
          3'd1: begin m_open[b] = 1'b1; m_row[b] = a[10:0]; end
          3'd2, 3'd3: begin m_cnt = m_bl; m_ap = f; m_apb = b; end
          3'd4: if (f) m_open = 2'b00; else m_open[b] = 1'b0;
          3'd6: m_bl = 1 << a[1:0];
          default: ;
        endcase
      end
      m_cmd = d; m_err = e;
      if (d != 3'd0) begin m_rowo = a[10:0]; m_col = a[7:0]; m_bank = b; m_flag = f; end
    end else begin
      m_cmd = 3'd0; m_err = 0;
    end
    @(negedge clk);
    compare_all();
  endtask

  localparam logic [2:0] NOPS = 3'b111, ACT = 3'b011, RD = 3'b101, WR = 3'b100,
                         PRE = 3'b010, REF = 3'b001, MRS = 3'b000;

  initial begin
    bit [31:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 cmd", 32'(cmd_o), 0);
    chk("R1 err", 32'(err_o), 0);
    chk("R1 bank_open", 32'(bank_open_o), 0);
    chk("R1 rows", 32'({open_row_a_o, open_row_b_o}), 0);

    // R1: default burst length 1 -> close one enabled edge after command
    step(1, 0, ACT, 12'h123);
    step(1, 0, RD, 12'h405);
    chk("R1 open before close", 32'(bank_open_o[0]), 1);
    step(1, 0, NOPS, 0);
    chk("R1 bl1 closed", 32'(bank_open_o[0]), 0);

    // R9: burst length 4, R8: close on 4th enabled edge
    step(1, 0, MRS, 12'h002);
    step(1, 0, ACT, 12'h8AA);
    step(1, 0, WR, 12'hC10);
    step(1, 0, NOPS, 0);
    step(1, 1, RD, 0);          // R3: deselected, burst keeps counting
    step(0, 0, ACT, 12'h0FF);   // R4: frozen, no count
    chk("R4 frozen cmd", 32'(cmd_o), 0);
    step(1, 0, NOPS, 0);
    chk("R9 open at 3rd", 32'(bank_open_o[1]), 1);
    step(1, 1, NOPS, 0);
    chk("R8 closed at 4th", 32'(bank_open_o[1]), 0);

    // R8: flag low keeps bank open
    step(1, 0, MRS, 12'h000);
    step(1, 0, ACT, 12'h055);
    step(1, 0, RD, 12'h011);
    step(1, 0, NOPS, 0);
    step(1, 0, NOPS, 0);
    chk("R8 stays open", 32'(bank_open_o[0]), 1);

    // R10 / R11 / R12: errors pulse one cycle
    step(1, 0, ACT, 12'h077);
    chk("R10 act open err", 32'(err_o), 1);
    chk("R10 row kept", 32'(open_row_a_o), 32'(11'h055));
    step(1, 0, NOPS, 0);
    chk("R12 err one cycle", 32'(err_o), 0);
    step(1, 0, REF, 0);
    chk("R11 ref err", 32'(err_o), 1);
    step(1, 0, PRE, 12'h400);    // R7: all banks
    step(1, 0, REF, 0);
    chk("R11 ref ok", 32'(err_o), 0);
    step(1, 0, WR, 12'h800);
    chk("R10 wr closed err", 32'(err_o), 1);
    step(1, 0, 3'b110, 0);
    chk("R2 110 nop", 32'(cmd_o), 0);

    // Sweep: pseudo-random command stream against the spec model
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 6000; i++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      step(lf[2:0] != 3'd0, lf[5:3] == 3'd0, lf[8:6], lf[20:9]);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule